// File: doc/BRIEF.md
# Board Interrupt Aggregation Controller

This block gathers service requests from the devices on a line card and presents them to the host bridge as one active-low interrupt. Six device requests are level signals: line loss of signal, line loss of lock, missing transmitter output, framer attention, clock fault and system fault. A seventh request comes from a built-in watchdog on the local peripheral bus. When a bus cycle starts and no data acknowledge comes back within a fixed window, the watchdog records a sticky timeout event so that software knows to retry the access.

All requests land in a pending register. A separate enable register selects which pending bits may drive the interrupt. The host reaches both registers through a small read/write port, with a one-bit register select. The level bits mirror their sources. The timeout bit is cleared only by writing 1 to it. The output line is registered, so it reacts one clock after the pending or enable state changes.

Control and status pins are plain wires with no handshake. A register write takes effect on the clock edge where the write strobe is high. Reads are combinational from the selected register.

Top module: `board_irq_agg`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_n_o` is high.
- R2: Pending bits 0 (line signal loss), 1 (lock loss), 2 (no transmit output), 3 (framer), 4 (clock fault) and 6 (system fault) each equal the level that their input had at the previous clock edge.
- R3: Select value 1 addresses the enable register. A write there stores bits 6..0 of the write data, and a read returns them.
- R4: `irq_n_o` is low in the cycle after an edge at which the pending register ANDed with the enable register was non-zero, and high otherwise.
- R5: Pending bit 5 is set at the 16th clock edge after the edge that sampled `lbus_start_i`, if `lbus_ack_i` was low at all 16 of those edges.
- R6: If `lbus_ack_i` is high at any of those 16 edges, the running window ends and bit 5 is not set by that window.
- R7: Once set, bit 5 stays set until a write with select 0 and write-data bit 5 equal to 1. Writing 0 to bit 5, or writing any value to the level bits, changes nothing.
- R8: If a timeout expires at the same edge as a write that clears bit 5, bit 5 ends up set.
- R9: A new `lbus_start_i` during a running window restarts that window from zero, and a start at the same edge as an acknowledge counts as a start.
- R10: Bit 7 of both registers is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| los_i | input | 1 | Line loss-of-signal request (level) |
| lol_i | input | 1 | Line loss-of-lock request (level) |
| ntx_i | input | 1 | No-transmitter-output request (level) |
| framer_i | input | 1 | Framer request (level) |
| clkerr_i | input | 1 | Clock fault request (level) |
| syserr_i | input | 1 | System fault request (level) |
| lbus_start_i | input | 1 | Local-bus cycle start pulse |
| lbus_ack_i | input | 1 | Local-bus data acknowledge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 pending, 1 enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_n_o | output | 1 | Combined active-low interrupt |

## Verification
The bench pins down the edges of the acknowledge window. A counter that is off by one would show bit 5 one edge early at edge 15 or one edge late at edge 17. It tests a restart in the middle of a window, which a design that ignores restarts would let expire on the first start's schedule. It also tests an acknowledge inside the window, which a design that ignores cancellation would still flag. The bench lines up a timeout expiry with a clear write to the same edge, where a design that gave priority to the clear would lose the event. It also writes zeros and all-ones to the pending register, where a design with the wrong clear mask would drop the sticky bit or freeze the level bits. Throughout, a behavioural model checks the registered one-cycle lag of the interrupt line cycle by cycle.

// File: rtl/board_irq_pkg.sv
package board_irq_pkg;
  localparam int unsigned IRQ_W   = 8;
  localparam int unsigned B_LOS   = 0;
  localparam int unsigned B_LOL   = 1;
  localparam int unsigned B_NTX   = 2;
  localparam int unsigned B_FRM   = 3;
  localparam int unsigned B_CLK   = 4;
  localparam int unsigned B_ATO   = 5;
  localparam int unsigned B_SYS   = 6;
  localparam logic [IRQ_W-1:0] LEVEL_MASK = 8'h5F;
  localparam logic [IRQ_W-1:0] LATCH_MASK = 8'h20;
  localparam logic [IRQ_W-1:0] LIVE_MASK  = LEVEL_MASK | LATCH_MASK;
  typedef enum logic {SEL_PEND = 1'b0, SEL_EN = 1'b1} reg_sel_e;
endpackage

// File: rtl/xfer_ack_timer.sv
module xfer_ack_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ack_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == LAST);
  assign expire_o = busy_q && !ack_i && at_end && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (ack_i || at_end) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: the window closes after an expiry
  p_window_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !busy_q);
  // R6: an acknowledge ends the running window
  p_ack_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ack_i && !start_i) |=> !busy_q);
  // R9: a start always opens a fresh window
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] LEVEL_MASK = '0,
  parameter logic [W-1:0] LATCH_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  assign pend_d = (level_i & LEVEL_MASK)
                | (LATCH_MASK & (set_i | (pend_q & ~clr_i)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (LATCH_MASK[i]) begin : g_sticky
      // R7: a latched bit holds without a clear
      p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[i] && !clr_i[i]) |=> pend_q[i]);
      // R8: a set beats a simultaneous clear
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> pend_q[i]);
    end else if (LEVEL_MASK[i]) begin : g_level
      // R2: a level bit mirrors its source one edge later
      p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q[i] == $past(level_i[i])));
    end
  end
endmodule

// File: rtl/irq_mask_merge.sv
module irq_mask_merge #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] EN_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pend_i,
  output logic [W-1:0] en_o,
  output logic         irq_n_o
);
  logic [W-1:0] en_q;
  logic         irq_n_q;
  logic         any_live;

  assign any_live = |(pend_i & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      irq_n_q <= 1'b1;
    end else begin
      if (en_wr_i) en_q <= wdata_i & EN_MASK;
      irq_n_q <= !any_live;
    end
  end

  assign en_o    = en_q;
  assign irq_n_o = irq_n_q;

  // R4: an enabled pending bit pulls the line low next cycle
  p_irq_assert_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_i & en_o)) |=> !irq_n_o);
  // R4: with nothing enabled and pending the line is released next cycle
  p_irq_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pend_i & en_o)) |=> irq_n_o);
  // R3: the enable register changes only on a write
  p_en_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_o));
endmodule

// File: rtl/board_irq_agg.sv
module board_irq_agg
  import board_irq_pkg::*;
#(
  parameter int unsigned ACK_LIMIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             los_i,
  input  logic             lol_i,
  input  logic             ntx_i,
  input  logic             framer_i,
  input  logic             clkerr_i,
  input  logic             syserr_i,
  input  logic             lbus_start_i,
  input  logic             lbus_ack_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [IRQ_W-1:0] reg_wdata_i,
  output logic [IRQ_W-1:0] reg_rdata_o,
  output logic             irq_n_o
);
  logic [IRQ_W-1:0] level_vec;
  logic [IRQ_W-1:0] set_vec;
  logic [IRQ_W-1:0] clr_vec;
  logic [IRQ_W-1:0] pend;
  logic [IRQ_W-1:0] en;
  logic             expire;
  logic             pend_wr;
  logic             en_wr;

  always_comb begin
    level_vec        = '0;
    level_vec[B_LOS] = los_i;
    level_vec[B_LOL] = lol_i;
    level_vec[B_NTX] = ntx_i;
    level_vec[B_FRM] = framer_i;
    level_vec[B_CLK] = clkerr_i;
    level_vec[B_SYS] = syserr_i;
  end

  assign pend_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_PEND);
  assign en_wr   = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_EN);
  assign clr_vec = pend_wr ? reg_wdata_i : '0;

  always_comb begin
    set_vec        = '0;
    set_vec[B_ATO] = expire;
  end

  xfer_ack_timer #(.LIMIT(ACK_LIMIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (lbus_start_i),
    .ack_i    (lbus_ack_i),
    .expire_o (expire)
  );

  irq_pend_bank #(.W(IRQ_W), .LEVEL_MASK(LEVEL_MASK), .LATCH_MASK(LATCH_MASK)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level_vec),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .pend_o  (pend)
  );

  irq_mask_merge #(.W(IRQ_W), .EN_MASK(LIVE_MASK)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_wr_i (en_wr),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend),
    .en_o    (en),
    .irq_n_o (irq_n_o)
  );

  assign reg_rdata_o = (reg_sel_e'(reg_sel_i) == SEL_EN) ? en : pend;

  // R10: reserved bits of the pending register never become set
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~LIVE_MASK) == '0));
  // R5: an expiry shows up in the pending register one edge later
  p_expire_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend[B_ATO]);
endmodule

// File: tb/board_irq_agg_bench.sv
module board_irq_agg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic los_i = 0, lol_i = 0, ntx_i = 0, framer_i = 0, clkerr_i = 0, syserr_i = 0;
  logic lbus_start_i = 0, lbus_ack_i = 0;
  logic reg_wr_i = 0, reg_sel_i = 0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic irq_n_o;

  always #5 clk = ~clk;

  board_irq_agg u_board_irq_agg (
    .clk(clk), .rst_n(rst_n), .los_i(los_i), .lol_i(lol_i), .ntx_i(ntx_i),
    .framer_i(framer_i), .clkerr_i(clkerr_i), .syserr_i(syserr_i),
    .lbus_start_i(lbus_start_i), .lbus_ack_i(lbus_ack_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_n_o(irq_n_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference model
  logic [7:0] m_pend = '0, m_en = '0;
  logic m_irq_n = 1'b1;
  bit   m_busy = 0;
  int   m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_en = '0; m_irq_n = 1'b1; m_busy = 0; m_cnt = 0;
    end else begin
      bit fire;
      logic [7:0] np;
      fire = m_busy && !lbus_ack_i && (m_cnt == 15) && !lbus_start_i;
      m_irq_n = ((m_pend & m_en) == 8'h00);
      np = {1'b0, syserr_i, 1'b0, clkerr_i, framer_i, ntx_i, lol_i, los_i};
      if (fire) np[5] = 1'b1;
      else if (reg_wr_i && !reg_sel_i && reg_wdata_i[5]) np[5] = 1'b0;
      else np[5] = m_pend[5];
      m_pend = np;
      if (reg_wr_i && reg_sel_i) m_en = reg_wdata_i & 8'h7F;
      if (lbus_start_i) begin m_busy = 1; m_cnt = 0; end
      else if (m_busy) begin
        if (lbus_ack_i || m_cnt == 15) begin m_busy = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      exp_rd = reg_sel_i ? m_en : m_pend;
      n_cmp++;
      if (irq_n_o !== m_irq_n) begin
        n_bad++;
        $display("FAIL R4 irq_n actual=%b expected=%b t=%0t", irq_n_o, m_irq_n, $time);
      end
      n_cmp++;
      if (reg_rdata_o !== exp_rd) begin
        n_bad++;
        $display("FAIL R2 rdata sel=%0d actual=%h expected=%h t=%0t", reg_sel_i, reg_rdata_o, exp_rd, $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr_i = 1; reg_sel_i = sel; reg_wdata_i = d;
    tick();
    reg_wr_i = 0; reg_wdata_i = '0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    reg_sel_i = sel; #1; d = reg_rdata_o;
  endtask

  task automatic src(input logic [7:0] v);
    los_i = v[0]; lol_i = v[1]; ntx_i = v[2]; framer_i = v[3]; clkerr_i = v[4]; syserr_i = v[6];
  endtask

  task automatic pulse_start();
    lbus_start_i = 1; tick(); lbus_start_i = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    rd(0, d); chk("R1 pending after reset", d, 8'h00);
    rd(1, d); chk("R1 enable after reset", d, 8'h00);
    chk("R1 irq_n after reset", {7'b0, irq_n_o}, 8'h01);

    // R3 and R10 enable register
    wr(1, 8'hFF);
    rd(1, d); chk("R3 R10 enable readback", d, 8'h7F);
    wr(1, 8'h00);

    // R2 level following, R4 line behaviour
    wr(1, 8'h7F);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = (8'h01 << i) & 8'h5F;
      src(v);
      tick();
      rd(0, d); chk("R2 level bit follows source", d, v);
      tick();
      chk("R4 irq_n after level", {7'b0, irq_n_o}, {7'b0, v == 8'h00});
    end
    src(8'h5B); tick(); rd(0, d); chk("R2 multi-source pattern", d, 8'h5B);
    wr(1, 8'h04); tick();
    chk("R4 masked sources keep line high", {7'b0, irq_n_o}, 8'h01);
    src(8'h00); tick(); tick();
    wr(1, 8'h7F);

    // R5 timeout window exactly 16 edges
    reg_sel_i = 0;
    pulse_start();
    for (int k = 1; k <= 15; k++) begin
      tick(); rd(0, d); chk("R5 no timeout before 16th edge", d & 8'h20, 8'h00);
    end
    tick(); rd(0, d); chk("R5 timeout at 16th edge", d & 8'h20, 8'h20);
    tick(); chk("R4 irq_n on timeout", {7'b0, irq_n_o}, 8'h00);

    // R7 sticky behaviour and write-zero
    wr(0, 8'h00); rd(0, d); chk("R7 write 0 keeps bit5", d & 8'h20, 8'h20);
    src(8'h41);
    wr(0, 8'hDF); rd(0, d); chk("R7 write to level bits ignored", d, 8'h61);
    src(8'h00); tick();
    wr(0, 8'h20); rd(0, d); chk("R7 write 1 clears bit5", d, 8'h00);
    tick(); chk("R4 line released", {7'b0, irq_n_o}, 8'h01);

    // R6 acknowledge inside window
    pulse_start();
    repeat (9) tick();
    lbus_ack_i = 1; tick(); lbus_ack_i = 0;
    repeat (20) tick();
    rd(0, d); chk("R6 ack cancels timeout", d & 8'h20, 8'h00);

    // R9 restart during window
    pulse_start();
    repeat (10) tick();
    pulse_start();
    for (int k = 1; k <= 15; k++) begin
      tick(); rd(0, d); chk("R9 restarted window not expired", d & 8'h20, 8'h00);
    end
    tick(); rd(0, d); chk("R9 restarted window expires", d & 8'h20, 8'h20);
    wr(0, 8'h20);

    // R9 start with ack in same cycle counts as start
    lbus_start_i = 1; lbus_ack_i = 1; tick(); lbus_start_i = 0; lbus_ack_i = 0;
    repeat (16) tick();
    rd(0, d); chk("R9 start beats ack", d & 8'h20, 8'h20);
    wr(0, 8'h20);

    // R8 set wins over clear
    pulse_start();
    repeat (15) tick();
    wr(0, 8'h20);
    rd(0, d); chk("R8 set beats clear", d & 8'h20, 8'h20);
    wr(0, 8'h20);
    rd(0, d); chk("R8 later clear works", d & 8'h20, 8'h00);

    // mixed traffic, checked every cycle by the model
    for (int c = 0; c < 600; c++) begin
      logic [31:0] r;
      r = $urandom;
      src({1'b0, r[0] & r[1], 1'b0, r[2] & r[3], r[4] & r[5], r[6] & r[7], r[8] & r[9], r[10] & r[11]});
      lbus_start_i = (r[16:12] == 5'd0);
      lbus_ack_i   = (r[19:17] == 3'd0) && r[20];
      reg_wr_i     = (r[23:21] == 3'd0);
      reg_sel_i    = r[24];
      reg_wdata_i  = {r[31:25], r[0]};
      tick();
    end
    reg_wr_i = 0; lbus_start_i = 0; lbus_ack_i = 0;
    tick();
    rd(1, d); chk("R10 reserved enable bit", d & 8'h80, 8'h00);
    rd(0, d); chk("R10 reserved pending bit", d & 8'h80, 8'h00);
    finish_run();
  end
endmodule